// File: doc/BRIEF.md
# Source-Sticky Write Buffer Allocator

This block sits in front of a set of four write-data buffers and decides, for every incoming write command, which buffer will hold that command's data. The chosen index goes out with the command so the command queue can tag it. The block keeps a count of outstanding commands for each buffer, and a drain pulse from the data path lowers that count by one.

A buffer is free when its count is zero. A write whose source ID differs from the last accepted write goes to a free buffer. A write that repeats the source ID of the immediately previous accepted write is pinned to that write's buffer, whether or not other buffers are free. This keeps one source's consecutive data in a single buffer, which is drained strictly first in, first out by the storage outside this block. The pinning rule is always on. When the chosen target cannot take the write, `wr_ready` drops and the write waits.

Top module: `wbuf_sticky_alloc`

## Requirements
- R1: After reset every buffer count is zero and no previous source is remembered, so the first valid write is ready and receives buffer 0.
- R2: A write whose source ID differs from the last accepted write (or with none remembered) receives the lowest-numbered buffer whose count is zero. A buffer with a non-zero count is never given to it.
- R3: A write whose source ID equals that of the immediately previous accepted write receives that write's buffer, even when a lower-numbered buffer is free and even when the pinned buffer has since drained to zero.
- R4: Each accepted write adds one to its buffer's count, and each drain pulse (`drain_valid` with `drain_buf` as the index) subtracts one. Both on the same buffer in one cycle leave the count unchanged. A buffer becomes free again only when its count returns to zero.
- R5: A drain pulse on a buffer whose count is zero is ignored: the count stays zero and the buffer stays free.
- R6: A write from a new source when no buffer has a zero count sees `wr_ready` low and is not accepted.
- R7: A pinned write whose buffer count is at its maximum (2^CNT_W - 1) sees `wr_ready` low and is not redirected to another buffer.
- R8: The remembered source and buffer change only on an accepted write. A stalled write leaves them untouched.
- R9: Freedom is judged from the counts held at the start of the cycle. A buffer draining from one to zero in the same cycle is not offered to a new source until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write command present |
| wr_src | input | SRC_W | Source ID of the write command |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_buf | output | 2 | Buffer index assigned to the write, valid while `wr_valid` and `wr_ready` are high |
| drain_valid | input | 1 | One command's data has left a buffer |
| drain_buf | input | 2 | Index of the buffer that was drained |

## Verification
Allocation and draining can fall in the same cycle, on the same buffer or on different ones. The stress cases are a pinned write that increments a buffer while a drain decrements it, and a drain that empties a buffer just as a new source looks for a free one. The bench provokes both with random source IDs from a narrow range, so that repeats are common, and with random drain pulses at varying rates, plus directed sequences for the same-cycle emptying case. Every cycle it compares `wr_ready` and `wr_buf` with a reference model whose counts are updated from pre-cycle values.

// File: rtl/wba_pkg.sv
// Package: shared constants and types for the write buffer allocator.
// Assumes the buffer count is fixed at four by the surrounding data path.
package wba_pkg;
    localparam int NUM_BUF = 4;
    localparam int BUF_IDX_W = $clog2(NUM_BUF);
    typedef logic [BUF_IDX_W-1:0] buf_idx_t;
endpackage

// File: rtl/wba_occ_cnt.sv
// Module: outstanding-command counter for one write buffer.
// Counts accepted writes up and drain pulses down. A drain at zero is dropped.
// Assumes the caller never increments while full is high.
module wba_occ_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic dec_eff;

    // Purpose: qualify the drain so a zero count never underflows.
    always_comb begin
        dec_eff = dec && (cnt != '0);
        empty   = (cnt == '0);
        full    = (cnt == CNT_MAX);
    end

    // Purpose: hold the outstanding count, net of same-cycle inc and dec.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !dec_eff) begin
            cnt <= cnt + 1'b1;
        end else if (!inc && dec_eff) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt != CNT_MAX));

    a_r5_drain_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dec && !inc) |=> (cnt == '0));

    a_r4_inc_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec && cnt != '0) |=> $stable(cnt));
endmodule

// File: rtl/wba_free_pick.sv
// Module: picks the lowest-numbered set bit of a free vector.
// Purely combinational; idx is meaningful only when any is high.
module wba_free_pick
    import wba_pkg::*;
(
    input  logic [NUM_BUF-1:0] free_vec,
    output logic               any,
    output buf_idx_t           idx
);
    // Purpose: scan from the top down so the lowest free index wins.
    always_comb begin
        idx = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (free_vec[i]) idx = buf_idx_t'(i);
        end
        any = |free_vec;
    end
endmodule

// File: rtl/wbuf_sticky_alloc.sv
// Module: assigns each write command to one of four write buffers.
// A write repeating the previous accepted source is pinned to that buffer;
// otherwise the lowest free (zero-count) buffer is used. Stalls with
// wr_ready low when the target cannot take the write.
// Assumes drains arrive in each buffer's storage order and never exceed
// the number of accepted writes on that buffer.
module wbuf_sticky_alloc
    import wba_pkg::*;
#(
    parameter int SRC_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [SRC_W-1:0] wr_src,
    output logic             wr_ready,
    output logic [1:0]       wr_buf,
    input  logic             drain_valid,
    input  logic [1:0]       drain_buf
);
    logic             last_vld;
    logic [SRC_W-1:0] last_src;
    buf_idx_t         last_buf;

    logic [NUM_BUF-1:0] inc_vec, dec_vec, empty_vec, full_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_BUF];

    logic     stick, any_free, accept;
    buf_idx_t pick_idx;

    // One occupancy counter per buffer.
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        // Purpose: route accept and drain strobes to buffer g.
        always_comb begin
            inc_vec[g] = accept && (wr_buf == buf_idx_t'(g));
            dec_vec[g] = drain_valid && (drain_buf == buf_idx_t'(g));
        end

        wba_occ_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .dec   (dec_vec[g]),
            .cnt   (cnt_arr[g]),
            .empty (empty_vec[g]),
            .full  (full_vec[g])
        );
    end

    wba_free_pick u_pick (
        .free_vec (empty_vec),
        .any      (any_free),
        .idx      (pick_idx)
    );

    // Purpose: choose between the pinned buffer and the lowest free one.
    always_comb begin
        stick    = last_vld && (wr_src == last_src);
        wr_ready = stick ? !full_vec[last_buf] : any_free;
        wr_buf   = stick ? last_buf : pick_idx;
        accept   = wr_valid && wr_ready;
    end

    // Purpose: remember the source and buffer of the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld <= 1'b0;
            last_src <= '0;
            last_buf <= '0;
        end else if (accept) begin
            last_vld <= 1'b1;
            last_src <= wr_src;
            last_buf <= wr_buf;
        end
    end

    a_r3_sticky_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_vld && wr_src == last_src) |-> (wr_buf == last_buf));

    a_r2_new_src_free: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !stick) |-> (cnt_arr[wr_buf] == '0));

    a_r2_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !stick) |->
            ((empty_vec & ((NUM_BUF'(1) << wr_buf) - NUM_BUF'(1))) == '0));

    a_r6_stall_none_free: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !stick && !wr_ready) |-> (empty_vec == '0));

    a_r7_stall_pinned_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && stick && !wr_ready) |-> (cnt_arr[last_buf] == {CNT_W{1'b1}}));

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(last_src) && $stable(last_vld) && $stable(last_buf)));
endmodule

// File: tb/wbuf_sticky_alloc_tb_top.sv
`timescale 1ns/1ps
module wbuf_sticky_alloc_tb_top;
    localparam int SRC_W = 4;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_valid;
    logic [SRC_W-1:0] wr_src;
    logic             wr_ready;
    logic [1:0]       wr_buf;
    logic             drain_valid;
    logic [1:0]       drain_buf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Reference model state
    int     m_cnt [4];
    bit     m_lvld;
    int     m_lsrc;
    int     m_lbuf;

    always #4 clk = ~clk;

    wbuf_sticky_alloc #(.SRC_W(SRC_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_src(wr_src),
        .wr_ready(wr_ready), .wr_buf(wr_buf),
        .drain_valid(drain_valid), .drain_buf(drain_buf)
    );

    function automatic bit m_stick(int src);
        return m_lvld && (src == m_lsrc);
    endfunction

    function automatic int m_lowest_free();
        for (int i = 0; i < 4; i++) if (m_cnt[i] == 0) return i;
        return -1;
    endfunction

    function automatic bit exp_ready(int src);
        if (m_stick(src)) return m_cnt[m_lbuf] < CMAX;
        return m_lowest_free() >= 0;
    endfunction

    function automatic int exp_buf(int src);
        if (m_stick(src)) return m_lbuf;
        return m_lowest_free();
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_valid = 1'b0; wr_src = '0;
        drain_valid = 1'b0; drain_buf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        m_lvld = 0; m_lsrc = 0; m_lbuf = 0;
    endtask

    // One cycle: drive, compare combinational outputs, then advance model.
    task automatic step(bit v, int src, bit dv, int db, string tag);
        bit er; int eb; bit acc; string t;
        @(negedge clk);
        wr_valid = v; wr_src = SRC_W'(src);
        drain_valid = dv; drain_buf = 2'(db);
        #1;
        er = exp_ready(src);
        eb = exp_buf(src);
        if (tag.len() != 0) t = tag;
        else if (m_stick(src)) t = er ? "R3" : "R7";
        else t = er ? "R2" : "R6";
        if (v) begin
            check(wr_ready == er, {t, " ready"}, wr_ready, er);
            if (er) check(wr_buf == 2'(eb), {t, " buf"}, wr_buf, eb);
        end
        acc = v && er;
        @(posedge clk);
        if (dv && m_cnt[db] > 0) m_cnt[db]--;
        if (acc) begin
            m_cnt[eb]++;
            m_lvld = 1; m_lsrc = src; m_lbuf = eb;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_valid = 1'b0; wr_src = '0;
        drain_valid = 1'b0; drain_buf = '0;

        // R1: reset state, first write gets buffer 0
        do_reset();
        step(1, 5, 0, 0, "R1");

        // R9: buffer 0 drains to zero in the same cycle a new source asks
        step(1, 6, 1, 0, "R9");
        // R4: buffer 0 free next cycle, new source takes it
        step(1, 7, 0, 0, "R4");
        // R3: repeat source pinned to buffer 0 though buffer 2 is free
        step(0, 0, 1, 0, "R4");
        step(1, 7, 0, 0, "R3");
        // R4: pinned write and drain on the same buffer in one cycle
        step(1, 7, 1, 0, "R4");

        // R5: drain on an empty buffer is ignored
        do_reset();
        step(0, 0, 1, 3, "R5");
        step(1, 1, 0, 0, "R5");
        step(1, 2, 0, 0, "R5");
        step(1, 3, 0, 0, "R5");
        step(1, 4, 0, 0, "R5");   // must get buffer 3
        // R6: all busy, new source stalls
        step(1, 9, 0, 0, "R6");
        // R8: stalled write did not replace the remembered source
        step(1, 4, 0, 0, "R8");

        // R7: pinned buffer fills to its maximum, then stalls
        do_reset();
        for (int i = 0; i < CMAX; i++) step(1, 11, 0, 0, "R7");
        step(1, 11, 0, 0, "R7");
        step(1, 11, 0, 0, "R7");
        step(1, 12, 0, 0, "R2");  // other source goes to buffer 1

        // Random phases with varying drain rates
        do_reset();
        for (int ph = 0; ph < 4; ph++) begin
            int drate = (ph == 0) ? 10 : (ph == 1) ? 40 : (ph == 2) ? 70 : 25;
            for (int c = 0; c < 1500; c++) begin
                int src = int'($urandom_range(0, 3));
                bit v   = ($urandom_range(0, 99) < 70);
                bit dv  = (int'($urandom_range(0, 99)) < drate);
                int db  = int'($urandom_range(0, 3));
                step(v, src, dv, db, "");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule